// File: doc/BRIEF.md
# Table-Driven Duty Ramp Sequencer

This block generates slowly varying duty values for a bank of PWM channels. A shared table of 9-bit duty entries is loaded through a simple index-and-data write port. Each channel is given a window of that table, bounded by a low and a high index, and walks through it one entry at a time. Each entry is held for a programmable number of millisecond ticks. The current index and the duty value read from the table at that index are presented on the channel's outputs, ready for a separate PWM generator.

A channel starts when its bit in the start vector is pulsed. It copies its configuration at that moment and runs from one end of its window:

- **Direction:** upward from the low index, or downward from the high index.
- **End dwell:** each end of the window can hold for extra steps.
- **Toggle:** the walk can bounce back and forth between the two ends.
- **Repeat:** the pattern can run endlessly, or stop after one pass.

Channels run independently of one another. All of them read the same table.

Top module: `duty_ramp_seq`

## Requirements
- R1: Synchronous reset clears every table entry to 0. After reset every channel shows busy=0, done=0, index 0 and duty 0.
- R2: Table writes take effect on the next clock edge. A write at an index of 47 or more is dropped. The duty output always equals the table entry at the channel's current index, which includes any entry rewritten while the channel is running. An index of 47 or more reads as duty 0.
- R3: A start bit sampled high does three things in the next cycle: it sets busy, it loads the channel's configuration, and it puts the index at its start point. The start point is the low index when the upward flag is 1, and the high index when the flag is 0.
- R4: While busy, a step ends on the rising tick edge that completes step_ms edges counted since the step began. The index changes in the cycle after that edge, and at no other time except a start.
- R5: Every visit to the high index lasts 1+pause_hi steps, and every visit to the low index lasts 1+pause_lo steps. A pause count of zero adds no extra steps.
- R6: With toggle set, the walk reverses at the far end and moves one entry back. Without repeat, it stops when it gets back to its start point.
- R7: With repeat set and toggle clear, the walk jumps back to the start point after the far end. With repeat and toggle both set, it bounces between the two ends without stopping.
- R8: When a single pass ends, done is high for exactly one cycle and busy falls in that same cycle. The index then holds the final entry and its duty value until the next start.
- R9: A start given while the channel is busy restarts it from its start point. The step timer and the pause counter are both cleared.
- R10: Changes to the configuration inputs while a channel is busy have no effect until that channel's next start.
- R11: Each start bit affects only its own channel. Channels keep independent positions and timers.
- R12: The tick input is edge-detected. Holding it high for many cycles counts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | Millisecond tick; its rising edge counts |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write index |
| tbl_wdata | input | 9 | Table write duty value |
| start | input | NUM_CH | Per-channel start strobes |
| cfg_step_ms | input | NUM_CH*9 | Step length in ticks, per channel |
| cfg_lo_idx | input | NUM_CH*6 | Low window index, per channel |
| cfg_hi_idx | input | NUM_CH*6 | High window index, per channel |
| cfg_up | input | NUM_CH | 1: start at low index and move up |
| cfg_repeat | input | NUM_CH | Run continuously |
| cfg_toggle | input | NUM_CH | Bounce between ends |
| cfg_pause_hi | input | NUM_CH*8 | Extra steps at the high index |
| cfg_pause_lo | input | NUM_CH*8 | Extra steps at the low index |
| cur_idx | output | NUM_CH*6 | Current table index, per channel |
| duty | output | NUM_CH*9 | Table value at current index |
| busy | output | NUM_CH | Channel is running |
| done | output | NUM_CH | One-cycle end-of-pass pulse |

## Verification
A bad step counter shifts every index change by whole tick intervals, so the index comparison catches it within one step. A bad pause or direction register sends the index to the wrong value at the first visit to a window end, which is a few steps after start. A lost configuration latch or a bad table read port shows up as a wrong duty in the same cycle. Because the reference is compared with the block on every clock, each such fault is reported in the cycle where it first reaches a port.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

    localparam int DUTY_W  = 9;
    localparam int STEP_W  = 9;
    localparam int PAUSE_W = 8;
    localparam int IDX_W   = 6;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [DUTY_W-1:0]  duty_t;
    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [PAUSE_W-1:0] pause_t;

    typedef struct packed {
        step_t  step_ms;
        idx_t   lo;
        idx_t   hi;
        logic   up;
        logic   rpt;
        logic   toggle;
        pause_t pause_hi;
        pause_t pause_lo;
    } ramp_cfg_t;

    function automatic idx_t idx_move(idx_t i, logic up);
        return up ? idx_t'(i + 1'b1) : idx_t'(i - 1'b1);
    endfunction

    function automatic pause_t end_dwell(ramp_cfg_t c, idx_t i);
        if (i == c.hi) return c.pause_hi;
        if (i == c.lo) return c.pause_lo;
        return '0;
    endfunction

endpackage

// File: rtl/ramp_lut_store.sv
module ramp_lut_store
    import ramp_seq_pkg::*;
#(
    parameter int DEPTH = 47,
    parameter int NRD   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  idx_t                waddr,
    input  duty_t               wdata,
    input  idx_t  [NRD-1:0]     rd_idx,
    output duty_t [NRD-1:0]     rd_data
);
    localparam idx_t DEPTH_I = idx_t'(DEPTH);

    duty_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (waddr < DEPTH_I)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] < DEPTH_I) ? mem[rd_idx[p]] : '0;
    end

endmodule

// File: rtl/ramp_step_timer.sv
module ramp_step_timer
    import ramp_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  run,
    input  logic  tick,
    input  step_t step_len,
    output logic  step_end
);
    step_t            cnt;
    logic [STEP_W:0]  cnt_inc;

    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign step_end = run && tick && !restart && (cnt_inc >= {1'b0, step_len});

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= step_end ? '0 : cnt_inc[STEP_W-1:0];
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (run && step_len != '0) |-> (cnt < step_len));

    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/ramp_chan.sv
module ramp_chan
    import ramp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      tick,
    input  ramp_cfg_t cfg_in,
    output idx_t      idx,
    output logic      busy,
    output logic      done
);
    ramp_cfg_t cfg_q;
    logic      dir_up;
    pause_t    pause_cnt;
    logic      step_end;
    logic      at_travel_end;
    logic      bounce;
    pause_t    dwell;

    ramp_step_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (start),
        .run      (busy),
        .tick     (tick),
        .step_len (cfg_q.step_ms),
        .step_end (step_end)
    );

    assign dwell         = end_dwell(cfg_q, idx);
    assign at_travel_end = dir_up ? (idx == cfg_q.hi) : (idx == cfg_q.lo);
    assign bounce        = cfg_q.toggle && ((dir_up == cfg_q.up) || cfg_q.rpt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            idx       <= '0;
            dir_up    <= 1'b0;
            pause_cnt <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cfg_q     <= cfg_in;
                idx       <= cfg_in.up ? cfg_in.lo : cfg_in.hi;
                dir_up    <= cfg_in.up;
                pause_cnt <= '0;
                busy      <= 1'b1;
            end else if (busy && step_end) begin
                if (pause_cnt < dwell) begin
                    pause_cnt <= pause_t'(pause_cnt + 1'b1);
                end else begin
                    pause_cnt <= '0;
                    if (!at_travel_end) begin
                        idx <= idx_move(idx, dir_up);
                    end else if (bounce) begin
                        dir_up <= !dir_up;
                        idx    <= idx_move(idx, !dir_up);
                    end else if (!cfg_q.toggle && cfg_q.rpt) begin
                        idx <= cfg_q.up ? cfg_q.lo : cfg_q.hi;
                    end else begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_idx_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!start && !tick) |=> $stable(idx));

    assert_idx_window_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx >= cfg_q.lo && idx <= cfg_q.hi));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(idx) && !busy));

endmodule

// File: rtl/duty_ramp_seq.sv
module duty_ramp_seq
    import ramp_seq_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 47
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ms_tick,
    input  logic                        tbl_we,
    input  logic [IDX_W-1:0]            tbl_addr,
    input  logic [DUTY_W-1:0]           tbl_wdata,
    input  logic [NUM_CH-1:0]           start,
    input  logic [NUM_CH*STEP_W-1:0]    cfg_step_ms,
    input  logic [NUM_CH*IDX_W-1:0]     cfg_lo_idx,
    input  logic [NUM_CH*IDX_W-1:0]     cfg_hi_idx,
    input  logic [NUM_CH-1:0]           cfg_up,
    input  logic [NUM_CH-1:0]           cfg_repeat,
    input  logic [NUM_CH-1:0]           cfg_toggle,
    input  logic [NUM_CH*PAUSE_W-1:0]   cfg_pause_hi,
    input  logic [NUM_CH*PAUSE_W-1:0]   cfg_pause_lo,
    output logic [NUM_CH*IDX_W-1:0]     cur_idx,
    output logic [NUM_CH*DUTY_W-1:0]    duty,
    output logic [NUM_CH-1:0]           busy,
    output logic [NUM_CH-1:0]           done
);
    logic                 tick_q;
    logic                 tick_pulse;
    idx_t  [NUM_CH-1:0]   ch_idx;
    duty_t [NUM_CH-1:0]   ch_duty;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= ms_tick;
    end
    assign tick_pulse = ms_tick && !tick_q;

    ramp_lut_store #(
        .DEPTH (LUT_DEPTH),
        .NRD   (NUM_CH)
    ) u_lut (
        .clk     (clk),
        .rst     (rst),
        .we      (tbl_we),
        .waddr   (tbl_addr),
        .wdata   (tbl_wdata),
        .rd_idx  (ch_idx),
        .rd_data (ch_duty)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ramp_cfg_t cfg_c;

        always_comb begin
            cfg_c.step_ms  = cfg_step_ms[c*STEP_W +: STEP_W];
            cfg_c.lo       = cfg_lo_idx[c*IDX_W +: IDX_W];
            cfg_c.hi       = cfg_hi_idx[c*IDX_W +: IDX_W];
            cfg_c.up       = cfg_up[c];
            cfg_c.rpt      = cfg_repeat[c];
            cfg_c.toggle   = cfg_toggle[c];
            cfg_c.pause_hi = cfg_pause_hi[c*PAUSE_W +: PAUSE_W];
            cfg_c.pause_lo = cfg_pause_lo[c*PAUSE_W +: PAUSE_W];
        end

        ramp_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .start  (start[c]),
            .tick   (tick_pulse),
            .cfg_in (cfg_c),
            .idx    (ch_idx[c]),
            .busy   (busy[c]),
            .done   (done[c])
        );

        assign cur_idx[c*IDX_W +: IDX_W]   = ch_idx[c];
        assign duty[c*DUTY_W +: DUTY_W]    = ch_duty[c];
    end

    assert_tick_edge_R12: assert property (@(posedge clk) disable iff (rst)
        (ms_tick && $past(ms_tick)) |-> !tick_pulse);

    assert_duty_oob_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_idx[IDX_W-1:0] >= idx_t'(LUT_DEPTH)) |-> (duty[DUTY_W-1:0] == '0));

endmodule

// File: tb/duty_ramp_seq_bench.sv
module duty_ramp_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 3;
    localparam int DEP  = 47;
    localparam int WD_MAX = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic tbl_we = 1'b0;
    logic [5:0] tbl_addr = '0;
    logic [8:0] tbl_wdata = '0;
    logic [NCH-1:0] start = '0;
    logic [NCH*9-1:0] cfg_step_ms = '0;
    logic [NCH*6-1:0] cfg_lo_idx = '0;
    logic [NCH*6-1:0] cfg_hi_idx = '0;
    logic [NCH-1:0] cfg_up = '0, cfg_repeat = '0, cfg_toggle = '0;
    logic [NCH*8-1:0] cfg_pause_hi = '0, cfg_pause_lo = '0;
    logic [NCH*6-1:0] cur_idx;
    logic [NCH*9-1:0] duty;
    logic [NCH-1:0] busy, done;

    duty_ramp_seq #(.NUM_CH(NCH), .LUT_DEPTH(DEP)) u_duty_ramp_seq (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .start(start),
        .cfg_step_ms(cfg_step_ms), .cfg_lo_idx(cfg_lo_idx), .cfg_hi_idx(cfg_hi_idx),
        .cfg_up(cfg_up), .cfg_repeat(cfg_repeat), .cfg_toggle(cfg_toggle),
        .cfg_pause_hi(cfg_pause_hi), .cfg_pause_lo(cfg_pause_lo),
        .cur_idx(cur_idx), .duty(duty), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    int tick_gap = 0;
    int tick_ph = 0;

    // reference model state
    int tbl [64];
    bit tprev;
    int m_idx[NCH], m_up[NCH], m_pc[NCH], m_busy[NCH], m_done[NCH], m_cnt[NCH];
    int c_step[NCH], c_lo[NCH], c_hi[NCH], c_dir[NCH], c_rpt[NCH], c_tog[NCH], c_ph[NCH], c_pl[NCH];

    function automatic int exp_duty(int ch);
        return (m_idx[ch] < DEP) ? tbl[m_idx[ch]] : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void advance(int ch);
        int dw;
        int far;
        dw = (m_idx[ch] == c_hi[ch]) ? c_ph[ch] : (m_idx[ch] == c_lo[ch]) ? c_pl[ch] : 0;
        if (m_pc[ch] < dw) begin
            m_pc[ch]++;
            return;
        end
        m_pc[ch] = 0;
        far = m_up[ch] ? c_hi[ch] : c_lo[ch];
        if (m_idx[ch] != far) begin
            m_idx[ch] += m_up[ch] ? 1 : -1;
        end else if (c_tog[ch] != 0 && (m_up[ch] == c_dir[ch] || c_rpt[ch] != 0)) begin
            m_up[ch] = 1 - m_up[ch];
            m_idx[ch] += m_up[ch] ? 1 : -1;
        end else if (c_tog[ch] == 0 && c_rpt[ch] != 0) begin
            m_idx[ch] = c_dir[ch] ? c_lo[ch] : c_hi[ch];
        end else begin
            m_busy[ch] = 0;
            m_done[ch] = 1;
        end
    endfunction

    function automatic void model_step();
        bit tp;
        if (rst) begin
            for (int i = 0; i < 64; i++) tbl[i] = 0;
            tprev = 0;
            for (int ch = 0; ch < NCH; ch++) begin
                m_idx[ch] = 0; m_up[ch] = 0; m_pc[ch] = 0;
                m_busy[ch] = 0; m_done[ch] = 0; m_cnt[ch] = 0;
                c_step[ch] = 0; c_lo[ch] = 0; c_hi[ch] = 0; c_dir[ch] = 0;
                c_rpt[ch] = 0; c_tog[ch] = 0; c_ph[ch] = 0; c_pl[ch] = 0;
            end
            return;
        end
        tp = ms_tick && !tprev;
        tprev = ms_tick;
        if (tbl_we && tbl_addr < DEP) tbl[tbl_addr] = tbl_wdata;
        for (int ch = 0; ch < NCH; ch++) begin
            m_done[ch] = 0;
            if (start[ch]) begin
                c_step[ch] = cfg_step_ms[ch*9 +: 9];
                c_lo[ch]   = cfg_lo_idx[ch*6 +: 6];
                c_hi[ch]   = cfg_hi_idx[ch*6 +: 6];
                c_dir[ch]  = cfg_up[ch];
                c_rpt[ch]  = cfg_repeat[ch];
                c_tog[ch]  = cfg_toggle[ch];
                c_ph[ch]   = cfg_pause_hi[ch*8 +: 8];
                c_pl[ch]   = cfg_pause_lo[ch*8 +: 8];
                m_idx[ch]  = c_dir[ch] ? c_lo[ch] : c_hi[ch];
                m_up[ch]   = c_dir[ch];
                m_pc[ch]   = 0;
                m_cnt[ch]  = 0;
                m_busy[ch] = 1;
            end else if (m_busy[ch] != 0 && tp) begin
                m_cnt[ch]++;
                if (m_cnt[ch] >= c_step[ch]) begin
                    m_cnt[ch] = 0;
                    advance(ch);
                end
            end
        end
    endfunction

    // one clock: model the edge just taken, compare, then drive the tick
    task automatic cycle();
        @(negedge clk);
        model_step();
        for (int ch = 0; ch < NCH; ch++) begin
            chk(cur_req, $sformatf("ch%0d idx", ch), int'(cur_idx[ch*6 +: 6]), m_idx[ch]);
            chk(cur_req, $sformatf("ch%0d duty", ch), int'(duty[ch*9 +: 9]), exp_duty(ch));
            chk(cur_req, $sformatf("ch%0d busy", ch), int'(busy[ch]), m_busy[ch]);
            chk(cur_req, $sformatf("ch%0d done", ch), int'(done[ch]), m_done[ch]);
        end
        if (tick_gap > 0) begin
            tick_ph = (tick_ph + 1) % tick_gap;
            ms_tick = (tick_ph == 0);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_cfg(int ch, int step, int lo, int hi, bit up, bit rpt, bit tog, int ph, int pl);
        cfg_step_ms[ch*9 +: 9] = 9'(step);
        cfg_lo_idx[ch*6 +: 6]  = 6'(lo);
        cfg_hi_idx[ch*6 +: 6]  = 6'(hi);
        cfg_up[ch]     = up;
        cfg_repeat[ch] = rpt;
        cfg_toggle[ch] = tog;
        cfg_pause_hi[ch*8 +: 8] = 8'(ph);
        cfg_pause_lo[ch*8 +: 8] = 8'(pl);
    endtask

    task automatic kick(int ch);
        start[ch] = 1'b1;
        cycle();
        start[ch] = 1'b0;
    endtask

    task automatic wr(int a, int d);
        tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = 9'(d);
        cycle();
        tbl_we = 1'b0;
    endtask

    task automatic wait_done(int ch, int maxc);
        for (int i = 0; i < maxc; i++) begin
            cycle();
            if (done[ch]) return;
        end
        chk(cur_req, "done never seen", 0, 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        for (int i = 0; i < WD_MAX; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int held;
        // R1 reset state
        cur_req = "R1";
        run(3);
        rst = 1'b0;
        cycle();
        for (int ch = 0; ch < NCH; ch++) begin
            chk("R1", "reset busy", int'(busy[ch]), 0);
            chk("R1", "reset idx", int'(cur_idx[ch*6 +: 6]), 0);
            chk("R1", "reset duty", int'(duty[ch*9 +: 9]), 0);
        end

        // R2 load table, with dropped writes at 47 and 63
        cur_req = "R2";
        for (int i = 0; i < DEP; i++) wr(i, (i * 37 + 5) % 512);
        wr(47, 511);
        wr(63, 500);

        // R4 R5 R8 single upward pass with end dwell
        cur_req = "R5";
        tick_gap = 3;
        set_cfg(0, 2, 3, 6, 1, 0, 0, 1, 2);
        kick(0);
        chk("R3", "start idx", int'(cur_idx[5:0]), 3);
        chk("R3", "start busy", int'(busy[0]), 1);
        wait_done(0, 600);
        chk("R8", "done high", int'(done[0]), 1);
        chk("R8", "busy low at done", int'(busy[0]), 0);
        chk("R8", "final idx", int'(cur_idx[5:0]), 6);
        cycle();
        chk("R8", "done one cycle", int'(done[0]), 0);
        run(10);
        chk("R8", "idx held", int'(cur_idx[5:0]), 6);
        chk("R8", "duty held", int'(duty[8:0]), (6 * 37 + 5) % 512);

        // R6 R7 R11: ch1 toggle+repeat downward at the top of the table, ch2 jump-back repeat
        cur_req = "R7";
        tick_gap = 2;
        set_cfg(1, 1, 40, 47, 0, 1, 1, 0, 1);
        set_cfg(2, 3, 0, 2, 1, 1, 0, 2, 0);
        start[1] = 1'b1; start[2] = 1'b1;
        cycle();
        start = '0;
        chk("R2", "idx 47 reads zero", int'(duty[17:9]), 0);
        chk("R11", "ch0 untouched", int'(cur_idx[5:0]), 6);
        run(300);
        chk("R7", "ch1 still busy", int'(busy[1]), 1);
        chk("R7", "ch2 still busy", int'(busy[2]), 1);

        // R9 restart while busy; R10 config change while busy ignored
        cur_req = "R9";
        set_cfg(1, 2, 10, 20, 1, 1, 1, 1, 1);
        kick(1);
        chk("R9", "restart idx", int'(cur_idx[11:6]), 10);
        cur_req = "R10";
        set_cfg(1, 1, 30, 33, 0, 0, 0, 0, 0);
        run(200);
        chk("R10", "window kept", int'(cur_idx[11:6] >= 10 && cur_idx[11:6] <= 20), 1);

        // R6 toggle single pass stops back at start point
        cur_req = "R6";
        set_cfg(0, 1, 10, 12, 1, 0, 1, 0, 0);
        kick(0);
        wait_done(0, 200);
        chk("R6", "toggle pass ends at start", int'(cur_idx[5:0]), 10);

        // R12 held tick counts once; R2 live rewrite
        cur_req = "R12";
        tick_gap = 0;
        ms_tick = 1'b0;
        start = '0;
        set_cfg(2, 1, 20, 30, 1, 0, 0, 0, 0);
        kick(2);
        run(2);
        ms_tick = 1'b1;
        run(10);
        held = int'(cur_idx[17:12]);
        chk("R12", "one step for held tick", held, 21);
        ms_tick = 1'b0;
        run(2);
        ms_tick = 1'b1;
        run(3);
        chk("R12", "next edge steps", int'(cur_idx[17:12]), 22);
        cur_req = "R2";
        wr(22, 341);
        chk("R2", "live rewrite", int'(duty[26:18]), 341);
        run(5);

        finish_run();
    end

endmodule